// File: doc/BRIEF.md
# Interrupt Source PQ State Buffer

This block holds a two-bit pending/queued state for each source in a small bank of interrupt sources. The P bit means an event has been forwarded and is awaiting end-of-interrupt. The Q bit means a further trigger arrived while P was set. Triggers are coalesced, so a source never has more than one event outstanding downstream. A trigger that lands while the source is pending is remembered in Q and replayed when software signals end-of-interrupt.

Triggers arrive as hardware pulses, one line per source, or as a store to a source's trigger page. Software reaches each source through a 4 KB page of a single-beat MMIO port. Special load offsets return the previous state and may overwrite it in the same operation. A store at offset zero of the management page ends the interrupt. Forwarded events leave through a valid/ready port that carries the source number. A round-robin arbiter chooses among sources that are waiting to be forwarded.

The address is split as `{region, source, offset[11:0]}`. Region 0 is the management page and region 1 is the trigger page.

Top module: `pq_state_buffer`

## Requirements
- R1: After reset every source reads PQ = 00, `fwdValid` is low and `mmioRvalid` is low.
- R2: A trigger, from a hardware pulse or from a trigger-page store, moves PQ as follows. 00 goes to 10 and one forward is requested for the source. 10 goes to 11, 11 stays 11 and 01 stays 01, and none of these three requests a forward.
- R3: A store at offset 0x000 of a management page ends the interrupt. 10 goes to 00. 11 goes to 10 and requests a fresh forward. 00 and 01 are left unchanged.
- R4: Every load gives `mmioRvalid` high in the following cycle, with read data in that same cycle. A load at offset 0x800 of a management page returns the current PQ with P in bit 1 and Q in bit 0. Bits 63:2 read zero, and the state is not changed.
- R5: Loads at management offsets 0xC00, 0xD00, 0xE00 and 0xF00 write PQ = 00, 01, 10 and 11 respectively, so offset bits 9:8 give the new value. Each returns the PQ from before the write and requests no forward. Writing 01 masks the source.
- R6: A store at offset 0x000 of a source's trigger page (address top bit = 1) acts as one trigger on that source.
- R7: When an MMIO operation and a hardware trigger reach the same source in one cycle, the MMIO operation is applied first and the trigger acts on its result. A load returns the state from before both.
- R8: When several sources wait to be forwarded, one is offered per cycle. The search starts at the index after the last accepted source and wraps from NUM_SRC-1 to 0. A source leaves the waiting set only when `fwdValid && fwdReady`.
- R9: While `fwdValid` is high and `fwdReady` is low, `fwdValid` stays high and `fwdSrc` does not change, even if other sources start waiting.
- R10: Accesses with no defined meaning have no effect and loads among them return zero. These are: management loads at any offset other than 0x800, 0xC00, 0xD00, 0xE00 and 0xF00; any load of a trigger page; and any store at an offset other than 0x000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| trigIn | input | NUM_SRC | Per-source hardware trigger pulses |
| mmioValid | input | 1 | MMIO access strobe, one cycle per access |
| mmioWrite | input | 1 | 1 = store, 0 = load |
| mmioAddr | input | 1+IDX_W+12 | {region, source, offset} |
| mmioRvalid | output | 1 | Load data valid, one cycle after the load |
| mmioRdata | output | 64 | Load data, PQ in bits 1:0 |
| fwdValid | output | 1 | A source event is offered downstream |
| fwdReady | input | 1 | Downstream accepts the offered event |
| fwdSrc | output | IDX_W | Source number of the offered event |

## Verification
A hardware trigger pulse and an MMIO operation can hit the same source in the same cycle. The bench provokes this by driving a trigger bit and an access to that source on one clock edge. It covers three pairings: a mask load, an end-of-interrupt store at state 11, and a trigger-page store. For each pairing the bench checks the returned value, the forward offer and the state read back afterwards against MMIO-then-trigger ordering. Forward arbitration can also coincide with new triggers. The bench stalls the downstream ready while other sources become pending and compares the order of acceptance with a rotation computed from the last source it accepted.

// File: rtl/pq_pkg.sv
package pq_pkg;
  localparam int PAGE_BITS = 12;
  localparam logic [11:0] OFF_ZERO = 12'h000;
  localparam logic [11:0] OFF_PEEK = 12'h800;

  // Strobes from the decoder to the datapath
  typedef struct packed {
    logic       rd;       // any load: return data next cycle
    logic       rdPq;     // load returns the PQ of the addressed source
    logic       setPq;    // overwrite PQ with setVal
    logic [1:0] setVal;
    logic       eoi;      // end-of-interrupt step
    logic       swTrig;   // trigger step from a trigger-page store
  } pqStrobe_t;

  // Returns {forward, nextPq}; bit 1 of pq is P, bit 0 is Q
  function automatic logic [2:0] trigStep(input logic [1:0] pq);
    case (pq)
      2'b00:   trigStep = {1'b1, 2'b10};
      2'b10:   trigStep = {1'b0, 2'b11};
      default: trigStep = {1'b0, pq};
    endcase
  endfunction

  function automatic logic [2:0] eoiStep(input logic [1:0] pq);
    case (pq)
      2'b10:   eoiStep = {1'b0, 2'b00};
      2'b11:   eoiStep = {1'b1, 2'b10};
      default: eoiStep = {1'b0, pq};
    endcase
  endfunction
endpackage

// File: rtl/pq_ctrl.sv
module pq_ctrl
  import pq_pkg::*;
#(
  parameter int IDX_W  = 4,
  parameter int ADDR_W = 1 + IDX_W + PAGE_BITS
) (
  input  logic              mmioValid,
  input  logic              mmioWrite,
  input  logic [ADDR_W-1:0] mmioAddr,
  output pqStrobe_t         strobe,
  output logic [IDX_W-1:0]  src
);
  logic [PAGE_BITS-1:0] offset;
  logic                 trigPage;

  assign offset   = mmioAddr[PAGE_BITS-1:0];
  assign trigPage = mmioAddr[ADDR_W-1];
  assign src      = mmioAddr[PAGE_BITS +: IDX_W];

  always_comb begin
    strobe = '0;
    if (mmioValid) begin
      if (!mmioWrite) begin
        strobe.rd = 1'b1;
        if (!trigPage) begin
          if (offset == OFF_PEEK) begin
            strobe.rdPq = 1'b1;
          end else if (offset[11:10] == 2'b11 && offset[7:0] == 8'h00) begin
            strobe.rdPq   = 1'b1;
            strobe.setPq  = 1'b1;
            strobe.setVal = offset[9:8];
          end
        end
      end else if (offset == OFF_ZERO) begin
        if (trigPage) strobe.swTrig = 1'b1;
        else          strobe.eoi    = 1'b1;
      end
    end
  end
endmodule

// File: rtl/pq_datapath.sv
module pq_datapath
  import pq_pkg::*;
#(
  parameter int NUM_SRC = 16,
  parameter int IDX_W   = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  pqStrobe_t          strobe,
  input  logic [IDX_W-1:0]   src,
  input  logic [NUM_SRC-1:0] trigIn,
  input  logic [NUM_SRC-1:0] acceptOh,
  output logic [NUM_SRC-1:0] fwdPend,
  output logic               rdValid,
  output logic [63:0]        rdData
);
  logic [1:0]         pqQ [NUM_SRC];
  logic [NUM_SRC-1:0] fwdPendQ;

  for (genvar g = 0; g < NUM_SRC; g++) begin : gSrc
    logic       hit;
    logic [1:0] pqNext;
    logic       fwdNew;
    logic [2:0] step;

    assign hit = (src == IDX_W'(g));

    always_comb begin
      pqNext = pqQ[g];
      fwdNew = 1'b0;
      step   = '0;
      if (hit && strobe.setPq) pqNext = strobe.setVal;
      if (hit && strobe.eoi) begin
        step   = eoiStep(pqNext);
        pqNext = step[1:0];
        fwdNew = fwdNew | step[2];
      end
      if (hit && strobe.swTrig) begin
        step   = trigStep(pqNext);
        pqNext = step[1:0];
        fwdNew = fwdNew | step[2];
      end
      if (trigIn[g]) begin
        step   = trigStep(pqNext);
        pqNext = step[1:0];
        fwdNew = fwdNew | step[2];
      end
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        pqQ[g]      <= 2'b00;
        fwdPendQ[g] <= 1'b0;
      end else begin
        pqQ[g]      <= pqNext;
        fwdPendQ[g] <= (fwdPendQ[g] & ~acceptOh[g]) | fwdNew;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdValid <= 1'b0;
      rdData  <= '0;
    end else begin
      rdValid <= strobe.rd;
      if (strobe.rd) begin
        rdData <= '0;
        if (strobe.rdPq && int'(src) < NUM_SRC) rdData[1:0] <= pqQ[src];
      end
    end
  end

  assign fwdPend = fwdPendQ;
endmodule

// File: rtl/pq_rr_arb.sv
module pq_rr_arb #(
  parameter int NUM_SRC = 16,
  parameter int IDX_W   = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] req,
  input  logic               ready,
  output logic               valid,
  output logic [IDX_W-1:0]   grant,
  output logic [NUM_SRC-1:0] acceptOh
);
  logic [IDX_W-1:0] ptrQ;
  logic             found;

  always_comb begin
    int idx;
    found = 1'b0;
    grant = '0;
    idx   = 0;
    for (int i = 0; i < NUM_SRC; i++) begin
      idx = int'(ptrQ) + i;
      if (idx >= NUM_SRC) idx = idx - NUM_SRC;
      if (!found && req[idx]) begin
        found = 1'b1;
        grant = IDX_W'(idx);
      end
    end
  end

  assign valid    = found;
  assign acceptOh = (valid && ready) ? (NUM_SRC'(1) << grant) : '0;

  // On a stall the pointer parks on the grant so the offer stays put
  always_ff @(posedge clk) begin
    if (!rstN) begin
      ptrQ <= '0;
    end else if (valid) begin
      if (!ready)                         ptrQ <= grant;
      else if (int'(grant) == NUM_SRC-1)  ptrQ <= '0;
      else                                ptrQ <= grant + IDX_W'(1);
    end
  end
endmodule

// File: rtl/pq_state_buffer.sv
module pq_state_buffer
  import pq_pkg::*;
#(
  parameter int NUM_SRC = 16,
  localparam int IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1,
  localparam int ADDR_W = 1 + IDX_W + PAGE_BITS
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] trigIn,
  input  logic               mmioValid,
  input  logic               mmioWrite,
  input  logic [ADDR_W-1:0]  mmioAddr,
  output logic               mmioRvalid,
  output logic [63:0]        mmioRdata,
  output logic               fwdValid,
  input  logic               fwdReady,
  output logic [IDX_W-1:0]   fwdSrc
);
  pqStrobe_t          strobe;
  logic [IDX_W-1:0]   accSrc;
  logic [NUM_SRC-1:0] fwdPend;
  logic [NUM_SRC-1:0] acceptOh;

  pq_ctrl #(.IDX_W(IDX_W), .ADDR_W(ADDR_W)) i_ctrl (
    .mmioValid(mmioValid), .mmioWrite(mmioWrite), .mmioAddr(mmioAddr),
    .strobe(strobe), .src(accSrc)
  );

  pq_datapath #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) i_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .src(accSrc), .trigIn(trigIn),
    .acceptOh(acceptOh), .fwdPend(fwdPend),
    .rdValid(mmioRvalid), .rdData(mmioRdata)
  );

  pq_rr_arb #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) i_arb (
    .clk(clk), .rstN(rstN), .req(fwdPend), .ready(fwdReady),
    .valid(fwdValid), .grant(fwdSrc), .acceptOh(acceptOh)
  );
endmodule

// File: rtl/pq_state_buffer_chk.sv
module pq_state_buffer_chk #(
  parameter int NUM_SRC = 16,
  parameter int IDX_W   = 4
) (
  input logic             clk,
  input logic             rstN,
  input logic             mmioValid,
  input logic             mmioWrite,
  input logic             mmioRvalid,
  input logic [63:0]      mmioRdata,
  input logic             fwdValid,
  input logic             fwdReady,
  input logic [IDX_W-1:0] fwdSrc
);
  assert_load_answers_R4: assert property (@(posedge clk) disable iff (!rstN)
    (mmioValid && !mmioWrite) |=> mmioRvalid);

  assert_no_stray_rvalid_R4: assert property (@(posedge clk) disable iff (!rstN)
    !(mmioValid && !mmioWrite) |=> !mmioRvalid);

  assert_rdata_narrow_R4: assert property (@(posedge clk) disable iff (!rstN)
    mmioRvalid |-> mmioRdata[63:2] == 62'd0);

  assert_stall_keeps_valid_R9: assert property (@(posedge clk) disable iff (!rstN)
    (fwdValid && !fwdReady) |=> fwdValid);

  assert_stall_keeps_src_R9: assert property (@(posedge clk) disable iff (!rstN)
    (fwdValid && !fwdReady) |=> $stable(fwdSrc));

  assert_src_in_range_R8: assert property (@(posedge clk) disable iff (!rstN)
    fwdValid |-> int'(fwdSrc) < NUM_SRC);
endmodule

bind pq_state_buffer pq_state_buffer_chk #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) i_chk (
  .clk(clk), .rstN(rstN), .mmioValid(mmioValid), .mmioWrite(mmioWrite),
  .mmioRvalid(mmioRvalid), .mmioRdata(mmioRdata), .fwdValid(fwdValid),
  .fwdReady(fwdReady), .fwdSrc(fwdSrc)
);

// File: tb/test_pq_state_buffer.sv
`timescale 1ns/1ps
module test_pq_state_buffer;
  localparam int N      = 16;
  localparam int IDX_W  = 4;
  localparam int ADDR_W = 1 + IDX_W + 12;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [N-1:0]      trigIn = '0;
  logic              mmioValid = 1'b0;
  logic              mmioWrite = 1'b0;
  logic [ADDR_W-1:0] mmioAddr = '0;
  logic              mmioRvalid;
  logic [63:0]       mmioRdata;
  logic              fwdValid;
  logic              fwdReady = 1'b0;
  logic [IDX_W-1:0]  fwdSrc;

  int total = 0;
  int bad   = 0;
  int lastAcc = N - 1;
  int seq [N];
  int seqLen;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  pq_state_buffer #(.NUM_SRC(N)) i_pq_state_buffer (
    .clk(clk), .rstN(rstN), .trigIn(trigIn), .mmioValid(mmioValid),
    .mmioWrite(mmioWrite), .mmioAddr(mmioAddr), .mmioRvalid(mmioRvalid),
    .mmioRdata(mmioRdata), .fwdValid(fwdValid), .fwdReady(fwdReady),
    .fwdSrc(fwdSrc)
  );

  function automatic logic [ADDR_W-1:0] mkAddr(input bit region, input int s, input int off);
    return {region, IDX_W'(s), 12'(off)};
  endfunction

  // bench model: returns fwd*4 + next pq
  function automatic int modelTrig(input int pq);
    if (pq == 0) return 4 + 2;
    if (pq == 2) return 3;
    return pq;
  endfunction
  function automatic int modelEoi(input int pq);
    if (pq == 2) return 0;
    if (pq == 3) return 4 + 2;
    return pq;
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one cycle: optional trigger mask plus optional MMIO access
  task automatic step(input logic [N-1:0] trg, input bit v, input bit w,
                      input logic [ADDR_W-1:0] a, output logic [63:0] rd);
    @(negedge clk);
    trigIn = trg; mmioValid = v; mmioWrite = w; mmioAddr = a;
    @(negedge clk);
    trigIn = '0; mmioValid = 1'b0; mmioWrite = 1'b0;
    rd = mmioRdata;
  endtask

  task automatic setPq(input int s, input int pq);
    logic [63:0] d;
    step('0, 1, 0, mkAddr(0, s, 'hC00 + pq * 'h100), d);
  endtask

  task automatic peek(input int s, output logic [63:0] d);
    step('0, 1, 0, mkAddr(0, s, 'h800), d);
  endtask

  task automatic drain(output int cnt);
    cnt = 0;
    @(negedge clk);
    fwdReady = 1'b1;
    for (int k = 0; k < 2 * N; k++) begin
      if (!fwdValid) break;
      seq[cnt] = int'(fwdSrc);
      lastAcc = int'(fwdSrc);
      cnt++;
      @(negedge clk);
    end
    fwdReady = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [63:0] d;
    int cnt, r, exp;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 rvalid", {63'd0, mmioRvalid}, 64'd0);
    check("R1 fwdValid", {63'd0, fwdValid}, 64'd0);
    rstN = 1'b1;
    for (int s = 0; s < N; s++) begin
      peek(s, d);
      check("R1 pq", d, 64'd0);
    end
    check("R4 rvalid after load", {63'd0, mmioRvalid}, 64'd1);

    // R5: set loads return old, write new, never forward
    for (int o = 0; o < 4; o++) begin
      for (int n = 0; n < 4; n++) begin
        setPq(5, o);
        step('0, 1, 0, mkAddr(0, 5, 'hC00 + n * 'h100), d);
        check("R5 old value", d, 64'(o));
        check("R5 no forward", {63'd0, fwdValid}, 64'd0);
        peek(5, d);
        check("R5 new value", d, 64'(n));
      end
    end

    // R2, R3, R6 sweeps over every source and start state
    for (int s = 0; s < N; s++) begin
      for (int pq = 0; pq < 4; pq++) begin
        for (int op = 0; op < 3; op++) begin
          setPq(s, pq);
          if (op == 0) begin
            step(N'(1) << s, 0, 0, '0, d);
            r = modelTrig(pq);
          end else if (op == 1) begin
            step('0, 1, 1, mkAddr(0, s, 0), d);
            r = modelEoi(pq);
          end else begin
            step('0, 1, 1, mkAddr(1, s, 0), d);
            r = modelTrig(pq);
          end
          check(op == 1 ? "R3 fwd" : (op == 0 ? "R2 fwd" : "R6 fwd"),
                {63'd0, fwdValid}, 64'(r / 4));
          if (r / 4 == 1) check("R2/R3 fwdSrc R8", 64'(fwdSrc), 64'(s));
          check("R4 no write on store", {63'd0, mmioRvalid}, 64'd0);
          peek(s, d);
          check(op == 1 ? "R3 pq" : (op == 0 ? "R2 pq" : "R6 pq"), d, 64'(r % 4));
          drain(cnt);
          check("R2 one event", 64'(cnt), 64'(r / 4));
        end
      end
    end

    // R7: same-cycle MMIO and hardware trigger
    setPq(3, 0);
    step(N'(1) << 3, 1, 0, mkAddr(0, 3, 'hD00), d);
    check("R7 mask load old", d, 64'd0);
    check("R7 mask then trig no fwd", {63'd0, fwdValid}, 64'd0);
    peek(3, d);
    check("R7 masked stays", d, 64'd1);
    setPq(3, 3);
    step(N'(1) << 3, 1, 1, mkAddr(0, 3, 0), d);
    check("R7 eoi then trig fwd", {63'd0, fwdValid}, 64'd1);
    peek(3, d);
    check("R7 eoi then trig pq", d, 64'd3);
    drain(cnt);
    check("R7 eoi then trig count", 64'(cnt), 64'd1);
    setPq(7, 0);
    step(N'(1) << 7, 1, 1, mkAddr(1, 7, 0), d);
    peek(7, d);
    check("R7 double trig pq", d, 64'd3);
    drain(cnt);
    check("R7 double trig count", 64'(cnt), 64'd1);

    // R8, R9: several waiting sources, stall then rotate
    for (int k = 0; k < 4; k++) setPq(1 + 4 * k, 0);
    step(16'h2222, 0, 0, '0, d);
    exp = -1;
    for (int k = 1; k <= N; k++) begin
      r = (lastAcc + k) % N;
      if (exp < 0 && r % 4 == 1) exp = r;
    end
    for (int k = 0; k < 3; k++) begin
      check("R9 stall valid", {63'd0, fwdValid}, 64'd1);
      check("R9 stall src", 64'(fwdSrc), 64'(exp));
      step('0, 0, 0, '0, d);
    end
    setPq(0, 0);
    setPq(14, 0);
    step(N'(1) | (N'(1) << 14), 0, 0, '0, d);
    check("R9 stall src after new req", 64'(fwdSrc), 64'(exp));
    r = lastAcc;
    drain(cnt);
    check("R8 count", 64'(cnt), 64'd6);
    exp = 0;
    for (int k = 1; k <= N; k++) begin
      int idx;
      idx = (r + k) % N;
      if (idx % 4 == 1 || idx == 0 || idx == 14) begin
        if (exp < cnt) check("R8 order", 64'(seq[exp]), 64'(idx));
        exp++;
      end
    end

    // R10: undefined accesses
    setPq(2, 2);
    step('0, 1, 0, mkAddr(0, 2, 'h400), d);
    check("R10 odd load zero", d, 64'd0);
    step('0, 1, 0, mkAddr(0, 2, 'hC10), d);
    check("R10 near-set load zero", d, 64'd0);
    step('0, 1, 0, mkAddr(1, 2, 0), d);
    check("R10 trig page load zero", d, 64'd0);
    step('0, 1, 1, mkAddr(0, 2, 'h800), d);
    step('0, 1, 1, mkAddr(1, 2, 'h008), d);
    check("R10 no fwd", {63'd0, fwdValid}, 64'd0);
    peek(2, d);
    check("R10 pq kept", d, 64'd2);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule